// File: doc/BRIEF.md
# Half-Band Decimate-by-Two Filter

This block is a linear-phase half-band FIR filter that lowers the sample rate by two. Input samples are 16-bit two's complement and arrive with a valid strobe. The block produces one filtered 16-bit sample for every two accepted inputs, and marks each one with a single-cycle valid pulse. It sits at the end of a decimating receive chain, where its narrow transition band around a quarter of the input rate suppresses aliasing before the rate is halved.

The block uses the half-band structure. Every coefficient at an even, nonzero distance from the centre is zero, so those taps are not computed. The remaining coefficients come in equal pairs, so each pair of samples is added before a single multiply. The centre weight is exactly one half and is applied with a shift. Coefficients are 18-bit signed values scaled by 2^17 and are held in a constant parameter. The sum keeps full precision until a final truncation to 16 bits. The sum is evaluated only on the accepted samples that produce an output.

Top module: `hb_decim2`

## Requirements
- R1: While reset is asserted, out_valid is low and out_data is zero. Reset also clears every delay stage and the decimation phase.
- R2: out_valid is a one-cycle pulse. It appears exactly one clock after every second accepted sample, counting from reset, and at no other time.
- R3: A cycle with in_valid low does not shift the delay line, does not advance the decimation phase and produces no output.
- R4: Let w0 be the sample accepted at the producing edge and wi the sample accepted i inputs earlier. The centre is c = (NTAPS-1)/2. Pair k uses bits [18k+17:18k] of COEFS, which weight offset d = 2k+1. The output is out_data = floor(S / 2^17) taken modulo 2^16, where S = 2^16*w_c + sum over k of COEFS_k*(w_{c-d} + w_{c+d}).
- R5: Samples at an even, nonzero offset from the centre have no effect on out_data.
- R6: A sample at offset -d from the centre is weighted the same as a sample at offset +d.
- R7: The centre weight is exactly one half. A lone value A at the centre tap gives floor(A/2).
- R8: out_data holds its value between output pulses.
- R9: Truncation is the only loss of precision, and it rounds toward minus infinity. For example, -1 at the centre alone gives -1, and +1 gives 0.
- R10: The first output after reset uses zeros for every sample older than the two accepted since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 16 | Input sample, two's complement |
| out_valid | output | 1 | One-cycle strobe for each decimated output |
| out_data | output | 16 | Decimated filtered sample, two's complement |

## Verification
The bench builds the block with NTAPS = 7. This gives two coefficient pairs, with weights 39322 and -6554, and six delay stages. With so short a window, an impulse can be walked through every tap position in both decimation alignments, so the zero taps, the symmetry and the centre half-weight each appear directly at the output. Full-scale and floor-rounding corners are also reachable, and an independent arithmetic model checks every output of a long pseudo-random stream with random idle gaps, including across a reset in mid-stream.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int HB_DATA_W = 16;
  localparam int HB_COEF_W = 18;

  // index of the centre tap in a window of n taps
  function automatic int hb_centre(input int n);
    return (n - 1) / 2;
  endfunction

  // number of nonzero symmetric coefficient pairs (n = 4*p - 1)
  function automatic int hb_npair(input int n);
    return (n + 1) / 4;
  endfunction

  // distance from the centre of pair k
  function automatic int hb_offset(input int k);
    return 2 * k + 1;
  endfunction
endpackage

// File: rtl/hb_delay.sv
module hb_delay #(
  parameter int DATA_W = 16,
  parameter int NTAPS  = 59,
  localparam int CTR   = hb_pkg::hb_centre(NTAPS),
  localparam int NPAIR = hb_pkg::hb_npair(NTAPS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    shift_en,
  input  logic [DATA_W-1:0]       din,
  output logic [DATA_W-1:0]       tap_ctr,
  output logic [NPAIR*DATA_W-1:0] tap_lo,
  output logic [NPAIR*DATA_W-1:0] tap_hi
);
  localparam int STAGES = NTAPS - 1;

  logic [STAGES*DATA_W-1:0] line_q;
  logic [NTAPS*DATA_W-1:0]  win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else if (shift_en) line_q <= {line_q[(STAGES-1)*DATA_W-1:0], din};
  end

  // slot 0 is the sample arriving now, slot i the one i inputs older
  assign win     = {line_q, din};
  assign tap_ctr = win[CTR*DATA_W +: DATA_W];

  for (genvar k = 0; k < NPAIR; k++) begin : g_tap
    localparam int OFF = hb_pkg::hb_offset(k);
    assign tap_lo[k*DATA_W +: DATA_W] = win[(CTR-OFF)*DATA_W +: DATA_W];
    assign tap_hi[k*DATA_W +: DATA_W] = win[(CTR+OFF)*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/hb_preadd.sv
module hb_preadd #(
  parameter int DATA_W = 16,
  parameter int NPAIR  = 15,
  localparam int SUM_W = DATA_W + 1
) (
  input  logic [NPAIR*DATA_W-1:0] tap_lo,
  input  logic [NPAIR*DATA_W-1:0] tap_hi,
  output logic [NPAIR*SUM_W-1:0]  pair_sum
);
  function automatic logic [SUM_W-1:0] fold(input logic [DATA_W-1:0] a,
                                            input logic [DATA_W-1:0] b);
    return {a[DATA_W-1], a} + {b[DATA_W-1], b};
  endfunction

  for (genvar k = 0; k < NPAIR; k++) begin : g_pair
    assign pair_sum[k*SUM_W +: SUM_W] =
      fold(tap_lo[k*DATA_W +: DATA_W], tap_hi[k*DATA_W +: DATA_W]);
  end
endmodule

// File: rtl/hb_mac.sv
module hb_mac #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 18,
  parameter int NPAIR  = 15,
  parameter logic [NPAIR*COEF_W-1:0] COEFS = '0,
  localparam int SUM_W = DATA_W + 1,
  localparam int ACC_W = SUM_W + COEF_W + $clog2(NPAIR + 1),
  localparam int FRAC  = COEF_W - 1
) (
  input  logic [DATA_W-1:0]       ctr,
  input  logic [NPAIR*SUM_W-1:0]  pair_sum,
  output logic [DATA_W-1:0]       y
);
  logic signed [ACC_W-1:0] acc;

  // centre weight 2^(FRAC-1) on a 2^FRAC scale is a plain shift
  function automatic logic signed [ACC_W-1:0] centre_term(input logic [DATA_W-1:0] x);
    logic signed [ACC_W-1:0] e;
    e = ACC_W'($signed(x));
    return e <<< (FRAC - 1);
  endfunction

  function automatic logic signed [ACC_W-1:0] pair_term(input logic [SUM_W-1:0] s,
                                                        input logic [COEF_W-1:0] c);
    return ACC_W'($signed(s)) * ACC_W'($signed(c));
  endfunction

  function automatic logic [DATA_W-1:0] trunc_out(input logic signed [ACC_W-1:0] a);
    logic signed [ACC_W-1:0] s;
    s = a >>> FRAC;
    return s[DATA_W-1:0];
  endfunction

  always_comb begin
    acc = centre_term(ctr);
    for (int k = 0; k < NPAIR; k++)
      acc = acc + pair_term(pair_sum[k*SUM_W +: SUM_W], COEFS[k*COEF_W +: COEF_W]);
  end

  assign y = trunc_out(acc);
endmodule

// File: rtl/hb_decim2.sv
module hb_decim2 #(
  parameter int DATA_W = hb_pkg::HB_DATA_W,
  parameter int COEF_W = hb_pkg::HB_COEF_W,
  parameter int NTAPS  = 59,
  localparam int NPAIR = hb_pkg::hb_npair(NTAPS),
  parameter logic [NPAIR*COEF_W-1:0] COEFS = {
    18'sd115,   -18'sd140,  18'sd203,   -18'sd314,  18'sd480,
    -18'sd713,  18'sd1023,  -18'sd1433, 18'sd1971,  -18'sd2696,
    18'sd3700,  -18'sd5209, 18'sd7794,  -18'sd13572, 18'sd41609}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam int SUM_W = DATA_W + 1;

  logic                    phase_q;
  logic                    keep_pulse;
  logic [DATA_W-1:0]       tap_ctr;
  logic [NPAIR*DATA_W-1:0] tap_lo;
  logic [NPAIR*DATA_W-1:0] tap_hi;
  logic [NPAIR*SUM_W-1:0]  pair_sum;
  logic [DATA_W-1:0]       y_next;

  // second accepted sample of each pair is the one that yields an output
  assign keep_pulse = in_valid & phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else if (in_valid) phase_q <= ~phase_q;
  end

  hb_delay #(.DATA_W(DATA_W), .NTAPS(NTAPS)) i_delay (
    .clk(clk), .rst_n(rst_n), .shift_en(in_valid), .din(in_data),
    .tap_ctr(tap_ctr), .tap_lo(tap_lo), .tap_hi(tap_hi)
  );

  hb_preadd #(.DATA_W(DATA_W), .NPAIR(NPAIR)) i_preadd (
    .tap_lo(tap_lo), .tap_hi(tap_hi), .pair_sum(pair_sum)
  );

  hb_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .NPAIR(NPAIR), .COEFS(COEFS)) i_mac (
    .ctr(tap_ctr), .pair_sum(pair_sum), .y(y_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= keep_pulse;
      if (keep_pulse) out_data <= y_next;
    end
  end
endmodule

// File: rtl/hb_decim2_chk.sv
module hb_decim2_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              phase_q,
  input logic              keep_pulse,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data
);
  // independent count of accepted samples modulo two
  logic par_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) par_q <= 1'b0;
    else if (in_valid) par_q <= ~par_q;
  end

  assert_pulse_after_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && par_q));

  assert_single_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_keep_to_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    keep_pulse |=> out_valid);

  assert_idle_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(phase_q));

  assert_hold_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));
endmodule

bind hb_decim2 hb_decim2_chk #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .phase_q(phase_q),
  .keep_pulse(keep_pulse), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/test_hb_decim2.sv
module test_hb_decim2;
  localparam int CLK_PERIOD = 10;
  localparam int NTAPS  = 7;
  localparam longint H1 = 39322;
  localparam longint H3 = -6554;
  localparam logic signed [17:0] C1 = 18'sd39322;
  localparam logic signed [17:0] C3 = -18'sd6554;
  localparam logic [35:0] COEFS = {C3, C1};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic [15:0] out_data;

  int unsigned checks = 0;
  int unsigned fails = 0;
  longint      hist [NTAPS];
  int          nvalid = 0;
  logic [15:0] last_out = '0;
  logic [31:0] rnd = 32'h1d2c3b4a;

  always #(CLK_PERIOD/2) clk = ~clk;

  hb_decim2 #(.NTAPS(NTAPS), .COEFS(COEFS)) i_hb_decim2 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [15:0] model_y();
    longint s;
    s = hist[3] * 65536 + H1 * (hist[2] + hist[4]) + H3 * (hist[0] + hist[6]);
    s = s >>> 17;
    return s[15:0];
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    for (int i = 0; i < NTAPS; i++) hist[i] = 0;
    nvalid = 0; last_out = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    check(out_data == 16'd0, "R1 out_data in reset", $signed(out_data), 0);
    rst_n = 1'b1;
  endtask

  task automatic send(input logic [15:0] x, input int idle, input string tag);
    logic [15:0] e;
    @(negedge clk);
    in_valid = 1'b1; in_data = x;
    for (int i = NTAPS-1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = longint'($signed(x));
    nvalid++;
    @(negedge clk);
    in_valid = 1'b0;
    if (nvalid % 2 == 0) begin
      e = model_y();
      check(out_valid == 1'b1, "R2 pulse on second sample", out_valid, 1);
      check(out_data == e, tag, $signed(out_data), $signed(e));
      last_out = out_data;
    end else begin
      check(out_valid == 1'b0, "R2 no pulse on first sample", out_valid, 0);
      check(out_data == last_out, "R8 hold after odd sample", $signed(out_data), $signed(last_out));
    end
    for (int j = 0; j < idle; j++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R3 idle cycle", out_valid, 0);
      check(out_data == last_out, "R8 hold while idle", $signed(out_data), $signed(last_out));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R10: first output sees only the two new samples
    send(16'd1000, 0, "R10 first output");
    send(16'd2000, 2, "R10 first output");

    // impulses through every tap in both alignments (R5 R6 R7 R9)
    for (int a = 0; a < 4; a++) begin
      for (int sh = 0; sh < 2; sh++) begin
        logic [15:0] amp;
        amp = (a == 0) ? 16'd12345 : (a == 1) ? -16'sd20000 : (a == 2) ? 16'hffff : 16'd1;
        do_reset();
        for (int z = 0; z < sh; z++) send(16'd0, 0, "R4 lead");
        send(amp, 1, "R5 R6 R7 R9 impulse");
        for (int z = 0; z < 8; z++) send(16'd0, z % 2, "R5 R6 R7 R9 impulse");
      end
    end

    // full-scale corners (R4)
    do_reset();
    for (int i = 0; i < 8; i++) send(16'h7fff, 0, "R4 full scale positive");
    for (int i = 0; i < 8; i++) send(16'h8000, 0, "R4 full scale negative");
    for (int i = 0; i < 8; i++) send((i % 2) ? 16'h8000 : 16'h7fff, 0, "R4 alternating");

    // random stream with gaps (R3 R4 R8)
    for (int i = 0; i < 800; i++) begin
      rnd = rnd ^ (rnd << 13); rnd = rnd ^ (rnd >> 17); rnd = rnd ^ (rnd << 5);
      send(rnd[15:0], int'(rnd[20:19]) % 3, "R4 random stream");
    end

    // reset in mid-stream (R1 R10)
    send(16'd777, 0, "R4 pre-reset");
    do_reset();
    send(-16'sd3000, 1, "R10 after mid reset");
    send(16'd5000, 1, "R10 after mid reset");
    send(16'd9000, 0, "R4 after mid reset");
    send(16'd100, 0, "R4 after mid reset");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule